// File: doc/BRIEF.md
# Microsecond Interval Timer Array

The block holds one system counter and one counter for each CPU. Every counter advances on a shared tick-enable that pulses once per microsecond. Each counter has a limit register. When the next count equals the nonzero limit, the counter reloads and latches an interrupt. The system counter feeds the level-10 clock interrupt line. Each CPU counter feeds the level-14 profiling line of its own CPU.

Software sees two registers per counter, a limit and a current count. Both hold a microsecond value placed at bit 10 and above. A period of P microseconds is therefore programmed as (P+1) shifted left by 10. Reading the limit register acknowledges that counter's interrupt. Rewriting a limit restarts the count at any time. A limit of zero leaves the counter free-running and silent. Software writes zero at start-up to disable the profiling timers.

Top module: `tmr_array`

## Requirements
- R1: The limit and count values sit in data bits 31:10. Bits 9:0 always read as 0, and write data in bits 9:0 is discarded.
- R2: While `tick` is high at a clock edge, each counter's count rises by one. Without `tick` the count holds.
- R3: Let a counter have a nonzero limit L. On a tick where count+1 equals L, the count reloads to 1 and that counter's interrupt output goes high after the edge. A limit of P+1 therefore interrupts every P ticks.
- R4: A pending interrupt stays high through further limit hits until it is acknowledged.
- R5: A read of the limit register (`addr`=0) returns the limit and clears that counter's interrupt. If a limit hit occurs in the same cycle, the interrupt stays set.
- R6: With a limit of 0 the counter counts freely, wrapping at its maximum, and never raises its interrupt.
- R7: A write to the limit register loads the limit and restarts the count at 1. This takes priority over a tick in the same cycle, and no hit is taken in that cycle.
- R8: The count register (`addr`=1) is read-only. Writes to it are ignored, and reading it leaves the interrupt unchanged.
- R9: Counter 0 drives `irq_sys` (level 10). Counter i (1..NUM_CPU) drives `irq_cpu[i-1]` (level 14). The counters act independently.
- R10: After reset every limit is 0, every count is 1 and all interrupt outputs are low.
- R11: Read data and `rd_valid` appear one cycle after `rd_en`. A `sel` beyond the last counter reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-microsecond count enable |
| sel | input | SEL_W | Counter select: 0 system, 1..NUM_CPU per CPU |
| addr | input | 1 | 0 limit register, 1 count register |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | Read data valid |
| irq_sys | output | 1 | Level-10 system timer interrupt |
| irq_cpu | output | NUM_CPU | Level-14 per-CPU profiling interrupts |

## Verification
The hardest case to produce is an acknowledging read that lands in the same cycle as a fresh limit hit. It only happens when a read strobe coincides with the one tick where count+1 equals the limit. The bench programs a limit of 2 and then raises `tick` together with a limit read in a single cycle. It expects the interrupt to survive that read and to clear only on a second, quiet read. A limit write issued together with a tick is driven the same way, to show the restart takes priority.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic {
    REG_LIMIT = 1'b0,
    REG_COUNT = 1'b1
  } tmr_reg_e;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 22
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             lim_we,
  input  logic [CNT_W-1:0] lim_wdata,
  input  logic             lim_rd,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] lim_o,
  output logic             pend_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, lim_q, cnt_inc;
  logic             pend_q, hit;

  assign cnt_inc = cnt_q + ONE;
  // a limit write in the same cycle suppresses any hit
  assign hit = tick && !lim_we && (lim_q != '0) && (cnt_inc == lim_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= ONE;
      lim_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (lim_we) begin
        lim_q <= lim_wdata;
        cnt_q <= ONE;
      end else if (tick) begin
        cnt_q <= hit ? ONE : cnt_inc;
      end
      if (hit)         pend_q <= 1'b1;
      else if (lim_rd) pend_q <= 1'b0;
    end
  end

  assign cnt_o  = cnt_q;
  assign lim_o  = lim_q;
  assign pend_o = pend_q;

  a_r4_pend_holds: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !lim_rd) |=> pend_q);
  a_r5_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (lim_rd && !tick) |=> !pend_q);
  a_r6_zero_limit_silent: assert property (@(posedge clk) disable iff (rst)
    (lim_q == '0 && !pend_q) |=> !pend_q);
  a_r7_write_restarts: assert property (@(posedge clk) disable iff (rst)
    lim_we |=> (cnt_q == ONE && lim_q == $past(lim_wdata)));
  a_r2_hold_no_tick: assert property (@(posedge clk) disable iff (rst)
    (!tick && !lim_we) |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_rdmux.sv
module tmr_rdmux #(
  parameter int NUM_CNT = 5,
  parameter int CNT_W   = 22,
  parameter int FRAC_W  = 10,
  parameter int SEL_W   = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    rd_en,
  input  logic [SEL_W-1:0]        sel,
  input  logic                    addr,
  input  logic [CNT_W-1:0]        cnt_all [NUM_CNT],
  input  logic [CNT_W-1:0]        lim_all [NUM_CNT],
  output logic [CNT_W+FRAC_W-1:0] rd_data,
  output logic                    rd_valid
);
  import tmr_pkg::*;

  logic [CNT_W-1:0] field;

  always_comb begin
    field = '0;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (sel == SEL_W'(i))
        field = (addr == REG_COUNT) ? cnt_all[i] : lim_all[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= {field, {FRAC_W{1'b0}}};
    end
  end

  a_r11_read_latency: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
  a_r1_low_bits_zero: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (rd_data[FRAC_W-1:0] == '0));
endmodule

// File: rtl/tmr_array.sv
module tmr_array #(
  parameter int NUM_CPU = 4,
  parameter int DATA_W  = 32,
  parameter int FRAC_W  = 10,
  parameter int SEL_W   = $clog2(NUM_CPU + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic [SEL_W-1:0]   sel,
  input  logic               addr,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [DATA_W-1:0]  wr_data,
  output logic [DATA_W-1:0]  rd_data,
  output logic               rd_valid,
  output logic               irq_sys,
  output logic [NUM_CPU-1:0] irq_cpu
);
  import tmr_pkg::*;

  localparam int NUM_CNT = NUM_CPU + 1;
  localparam int CNT_W   = DATA_W - FRAC_W;

  logic [CNT_W-1:0] cnt_all [NUM_CNT];
  logic [CNT_W-1:0] lim_all [NUM_CNT];
  logic [NUM_CNT-1:0] pend;

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    logic hit_sel;
    assign hit_sel = (sel == SEL_W'(g)) && (addr == REG_LIMIT);
    tmr_counter #(.CNT_W(CNT_W)) i_cnt (
      .clk       (clk),
      .rst       (rst),
      .tick      (tick),
      .lim_we    (wr_en && hit_sel),
      .lim_wdata (wr_data[DATA_W-1:FRAC_W]),
      .lim_rd    (rd_en && hit_sel),
      .cnt_o     (cnt_all[g]),
      .lim_o     (lim_all[g]),
      .pend_o    (pend[g])
    );
  end

  tmr_rdmux #(
    .NUM_CNT (NUM_CNT),
    .CNT_W   (CNT_W),
    .FRAC_W  (FRAC_W),
    .SEL_W   (SEL_W)
  ) i_rdmux (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .sel      (sel),
    .addr     (addr),
    .cnt_all  (cnt_all),
    .lim_all  (lim_all),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

  assign irq_sys = pend[0];
  assign irq_cpu = pend[NUM_CNT-1:1];

  a_r10_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!irq_sys && irq_cpu == '0));
endmodule

// File: tb/test_tmr_array.sv
module test_tmr_array;
  localparam int NUM_CPU = 4;
  localparam int SEL_W   = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0, addr = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [SEL_W-1:0] sel = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic rd_valid, irq_sys;
  logic [NUM_CPU-1:0] irq_cpu;

  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  tmr_array #(.NUM_CPU(NUM_CPU)) i_tmr_array (
    .clk(clk), .rst(rst), .tick(tick), .sel(sel), .addr(addr),
    .wr_en(wr_en), .rd_en(rd_en), .wr_data(wr_data),
    .rd_data(rd_data), .rd_valid(rd_valid),
    .irq_sys(irq_sys), .irq_cpu(irq_cpu)
  );

  typedef struct packed {
    logic [1:0]  op;   // 0 write, 1 read+check, 2 tick N, 3 irq check
    logic [2:0]  sel;
    logic        addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [23:0] tag;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    '{2'd3, 3'd0, 1'b0, 32'h0,        32'h0,    "R10"},
    '{2'd1, 3'd0, 1'b1, 32'h0,        32'h400,  "R10"},
    '{2'd0, 3'd0, 1'b0, 32'h1403,     32'h0,    "R1 "},
    '{2'd1, 3'd0, 1'b0, 32'h0,        32'h1400, "R1 "},
    '{2'd2, 3'd0, 1'b0, 32'd3,        32'h0,    "R2 "},
    '{2'd1, 3'd0, 1'b1, 32'h0,        32'h1000, "R2 "},
    '{2'd2, 3'd0, 1'b0, 32'd1,        32'h0,    "R3 "},
    '{2'd3, 3'd0, 1'b0, 32'h0,        32'h1,    "R3 "},
    '{2'd1, 3'd0, 1'b1, 32'h0,        32'h400,  "R3 "},
    '{2'd2, 3'd0, 1'b0, 32'd4,        32'h0,    "R4 "},
    '{2'd3, 3'd0, 1'b0, 32'h0,        32'h1,    "R4 "},
    '{2'd1, 3'd0, 1'b0, 32'h0,        32'h1400, "R5 "},
    '{2'd3, 3'd0, 1'b0, 32'h0,        32'h0,    "R5 "},
    '{2'd0, 3'd2, 1'b0, 32'hC00,      32'h0,    "R9 "},
    '{2'd2, 3'd0, 1'b0, 32'd2,        32'h0,    "R9 "},
    '{2'd3, 3'd0, 1'b0, 32'h0,        32'h4,    "R9 "},
    '{2'd0, 3'd1, 1'b1, 32'hFFFFFC00, 32'h0,    "R8 "},
    '{2'd1, 3'd1, 1'b1, 32'h0,        32'h2C00, "R8 "},
    '{2'd1, 3'd2, 1'b1, 32'h0,        32'h400,  "R8 "},
    '{2'd3, 3'd0, 1'b0, 32'h0,        32'h4,    "R8 "},
    '{2'd1, 3'd2, 1'b0, 32'h0,        32'hC00,  "R5 "},
    '{2'd0, 3'd0, 1'b0, 32'h0,        32'h0,    "R6 "},
    '{2'd2, 3'd0, 1'b0, 32'd10,       32'h0,    "R6 "},
    '{2'd3, 3'd0, 1'b0, 32'h0,        32'h4,    "R6 "},
    '{2'd1, 3'd0, 1'b1, 32'h0,        32'h2C00, "R6 "}
  };

  task automatic check(input logic [23:0] tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic t, input logic w, input logic r,
                     input logic [2:0] s, input logic a, input logic [31:0] d);
    @(negedge clk);
    tick = t; wr_en = w; rd_en = r; sel = s; addr = a; wr_data = d;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10: outputs quiet after reset
    check("R10", {27'd0, irq_cpu, irq_sys}, 32'h0);
    for (int i = 0; i < NV; i++) begin
      case (VECS[i].op)
        2'd0: bus(1'b0, 1'b1, 1'b0, VECS[i].sel, VECS[i].addr, VECS[i].data);
        2'd1: begin
          bus(1'b0, 1'b0, 1'b1, VECS[i].sel, VECS[i].addr, 32'h0);
          check(VECS[i].tag, rd_data, VECS[i].exp);
          check("R11", {31'd0, rd_valid}, 32'h1);
        end
        2'd2: ticks(int'(VECS[i].data));
        default: check(VECS[i].tag, {27'd0, irq_cpu, irq_sys}, VECS[i].exp);
      endcase
    end
    // R5 corner: acknowledge read coincides with a limit hit on counter 3
    bus(1'b0, 1'b1, 1'b0, 3'd3, 1'b0, 32'h800);
    bus(1'b1, 1'b0, 1'b1, 3'd3, 1'b0, 32'h0);
    check("R5 ", rd_data, 32'h800);
    check("R5 ", {31'd0, irq_cpu[2]}, 32'h1);
    bus(1'b0, 1'b0, 1'b1, 3'd3, 1'b0, 32'h0);
    check("R5 ", {31'd0, irq_cpu[2]}, 32'h0);
    // R7: limit write with a simultaneous tick restarts count at 1
    bus(1'b0, 1'b1, 1'b0, 3'd4, 1'b0, 32'h1000);
    ticks(2);
    bus(1'b1, 1'b1, 1'b0, 3'd4, 1'b0, 32'h1000);
    bus(1'b0, 1'b0, 1'b1, 3'd4, 1'b1, 32'h0);
    check("R7 ", rd_data, 32'h400);
    check("R7 ", {31'd0, irq_cpu[3]}, 32'h0);
    // R11: unmapped select reads zero
    bus(1'b0, 1'b0, 1'b1, 3'd6, 1'b0, 32'h0);
    check("R11", rd_data, 32'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule